// File: doc/BRIEF.md
# Remote Register Command Channel

This block lets a processor reach registers inside a remote power-management device through a single command register and a single status word. Software writes one command word that holds a direction bit, a halved register address and, for writes, the data. The block latches that word and runs a four-state machine. The machine issues the transfer on a simple request/acknowledge bus toward the device.

A write finishes as soon as the device acknowledges the request. A read needs a second acknowledge, which delivers the data. After that the machine parks in a wait-for-clear state and keeps the data visible until software writes the valid-clear register. The status word always shows the machine state, the last read data, the device-initialized flag and a sticky flag for rejected commands. Software is expected to poll for the idle state before it issues a command. The serial link, the arbitration among several masters and the initialization sequence are outside this block. Initialization arrives as a single level input.

Top module: `rch_top`

## Requirements
- R1: After a synchronous active-high reset, the state field reads IDLE (0), the read data is 0, dev_req is 0 and the error flag is 0.
- R2: A write to register offset 0 (command) while the state is IDLE and init_done is high is accepted. At the next edge the state becomes REQ (2) and dev_req rises. dev_we takes command bit 31 (1 = write, 0 = read), dev_addr takes command bits 30:16 (the target address shifted right by one), and dev_wdata takes command bits 15:0.
- R3: In REQ, dev_req and the latched dev_we, dev_addr and dev_wdata hold until dev_ack is seen at an edge. For a write, that edge also returns the state to IDLE and drops dev_req.
- R4: For a read, dev_ack in REQ moves the state to WFDLE (4) and drops dev_req. The next dev_ack in WFDLE captures dev_rdata into status bits 15:0 and moves the state to WFVLDCLR (6).
- R5: In WFVLDCLR, the state and read data hold until a write to register offset 1 (valid-clear) with data bit 0 set. That write returns the state to IDLE. The read data stays visible until the next read completes.
- R6: A valid-clear write has no effect in any state other than WFVLDCLR, and also has no effect when data bit 0 is 0. Writes to offsets 2 and 3 have no effect.
- R7: A command write while the state is not IDLE, or while init_done is low, is ignored. It sets the error flag (status bit 20), which stays set until reset.
- R8: The status word is laid out as follows: bits 15:0 hold the read data, bits 18:16 the state, bit 19 the value init_done had at the previous clock edge, bit 20 the error flag, and bits 31:21 read 0.
- R9: dev_ack is ignored in IDLE and in WFVLDCLR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Remote device initialization complete |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset (0 command, 1 valid-clear) |
| reg_wdata | input | 32 | Register write data |
| status | output | 32 | Status word |
| dev_req | output | 1 | Transfer request to remote device |
| dev_we | output | 1 | Transfer direction, 1 = write |
| dev_addr | output | 15 | Halved target register address |
| dev_wdata | output | 16 | Write data toward the device |
| dev_ack | input | 1 | Device acknowledge |
| dev_rdata | input | 16 | Read data from the device |

## Verification
The hardest cases to reach are collisions. These are a command or valid-clear write that lands in the same cycle as an acknowledge, an acknowledge in a state that must ignore it, and a command that arrives just as init_done drops. Directed sequences first cover clean reads and writes, each rejection cause and each ignored valid-clear. A long stretch of random register writes, acknowledges and init_done toggles then piles these events on every state. Throughout, a behavioural model in the bench is compared with every output on every cycle.

// File: rtl/rch_pkg.sv
package rch_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 15;
  localparam int WORD_W = 32;
  localparam int ST_W   = 3;
  localparam int ST_LSB = DATA_W;
  localparam int INIT_BIT = DATA_W + ST_W;
  localparam int ERR_BIT  = DATA_W + ST_W + 1;

  typedef enum logic [ST_W-1:0] {
    CH_IDLE = 3'd0,
    CH_REQ  = 3'd2,
    CH_WDAT = 3'd4,
    CH_WCLR = 3'd6
  } ch_state_t;

  localparam logic [1:0] OFS_CMD  = 2'd0;
  localparam logic [1:0] OFS_VCLR = 2'd1;
endpackage

// File: rtl/rch_reg_decode.sv
module rch_reg_decode
  import rch_pkg::*;
(
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic              cmd_wr,
  output logic              clr_wr,
  output logic [WORD_W-1:0] cmd_word
);
  always_comb begin
    cmd_wr   = reg_wr && (reg_addr == OFS_CMD);
    clr_wr   = reg_wr && (reg_addr == OFS_VCLR) && reg_wdata[0];
    cmd_word = reg_wdata;
  end
endmodule

// File: rtl/rch_fsm.sv
module rch_fsm
  import rch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_go,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              clr_go,
  input  logic              dev_ack,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic              dev_req,
  output logic              dev_we,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_wdata,
  output logic [DATA_W-1:0] rd_data,
  output ch_state_t         state
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CH_IDLE;
      dev_req   <= 1'b0;
      dev_we    <= 1'b0;
      dev_addr  <= '0;
      dev_wdata <= '0;
      rd_data   <= '0;
    end else begin
      unique case (state)
        CH_IDLE: if (cmd_go) begin
          state     <= CH_REQ;
          dev_req   <= 1'b1;
          dev_we    <= cmd_word[WORD_W-1];
          dev_addr  <= cmd_word[DATA_W +: ADDR_W];
          dev_wdata <= cmd_word[DATA_W-1:0];
        end
        CH_REQ: if (dev_ack) begin
          dev_req <= 1'b0;
          state   <= dev_we ? CH_IDLE : CH_WDAT;
        end
        CH_WDAT: if (dev_ack) begin
          rd_data <= dev_rdata;
          state   <= CH_WCLR;
        end
        CH_WCLR: if (clr_go) state <= CH_IDLE;
        default: state <= CH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rch_status.sv
module rch_status
  import rch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              init_done,
  input  logic              reject,
  input  ch_state_t         state,
  input  logic [DATA_W-1:0] rd_data,
  output logic              init_q,
  output logic [WORD_W-1:0] status
);
  logic err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= 1'b0;
      init_q <= 1'b0;
    end else begin
      init_q <= init_done;
      if (reject) err_q <= 1'b1;
    end
  end

  always_comb begin
    status = '0;
    status[DATA_W-1:0]       = rd_data;
    status[ST_LSB +: ST_W]   = state;
    status[INIT_BIT]         = init_q;
    status[ERR_BIT]          = err_q;
  end
endmodule

// File: rtl/rch_top.sv
module rch_top
  import rch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              init_done,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] status,
  output logic              dev_req,
  output logic              dev_we,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_wdata,
  input  logic              dev_ack,
  input  logic [DATA_W-1:0] dev_rdata
);
  logic              cmd_wr, clr_wr, cmd_go, reject, init_q;
  logic [WORD_W-1:0] cmd_word;
  logic [DATA_W-1:0] rd_data;
  ch_state_t         state;

  rch_reg_decode u_dec (
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .cmd_wr(cmd_wr), .clr_wr(clr_wr), .cmd_word(cmd_word)
  );

  always_comb begin
    cmd_go = cmd_wr && (state == CH_IDLE) && init_done;
    reject = cmd_wr && !cmd_go;
  end

  rch_fsm u_fsm (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_word(cmd_word),
    .clr_go(clr_wr), .dev_ack(dev_ack), .dev_rdata(dev_rdata),
    .dev_req(dev_req), .dev_we(dev_we), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .rd_data(rd_data), .state(state)
  );

  rch_status u_stat (
    .clk(clk), .rst(rst), .init_done(init_done), .reject(reject),
    .state(state), .rd_data(rd_data), .init_q(init_q), .status(status)
  );
endmodule

// File: rtl/rch_checker.sv
module rch_checker
  import rch_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              init_done,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [WORD_W-1:0] reg_wdata,
  input logic [WORD_W-1:0] status,
  input logic              dev_req,
  input logic [ADDR_W-1:0] dev_addr,
  input logic              dev_ack
);
  logic [ST_W-1:0] st;
  logic cmd_w, clr_w;
  assign st    = status[ST_LSB +: ST_W];
  assign cmd_w = reg_wr && reg_addr == OFS_CMD;
  assign clr_w = reg_wr && reg_addr == OFS_VCLR && reg_wdata[0];

  // R2
  cmd_start_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_w && st == 3'd0 && init_done) |=> (st == 3'd2 && dev_req));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_req && !dev_ack) |=> (dev_req && $stable(dev_addr)));

  // R5
  wclr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd6 && !clr_w) |=> (st == 3'd6 && $stable(status[DATA_W-1:0])));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    status[ERR_BIT] |=> status[ERR_BIT]);

  // R9
  idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (st == 3'd0 && !cmd_w) |=> (st == 3'd0 && !dev_req));

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    status[WORD_W-1:ERR_BIT+1] == '0);
endmodule

bind rch_top rch_checker u_chk (
  .clk(clk), .rst(rst), .init_done(init_done), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status(status),
  .dev_req(dev_req), .dev_addr(dev_addr), .dev_ack(dev_ack)
);

// File: tb/tb_rch_top.sv
module tb_rch_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_done = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] status;
  logic        dev_req, dev_we;
  logic [14:0] dev_addr;
  logic [15:0] dev_wdata;
  logic        dev_ack = 1'b0;
  logic [15:0] dev_rdata = '0;

  rch_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit started = 0, done = 0;

  // behavioural reference
  int m_state = 0, m_rd = 0, m_addr = 0, m_wd = 0;
  bit m_req = 0, m_we = 0, m_err = 0, m_init = 0;

  always @(posedge clk) begin
    bit cmd, clr;
    started = 1;
    if (rst) begin
      m_state = 0; m_rd = 0; m_req = 0; m_we = 0; m_addr = 0; m_wd = 0;
      m_err = 0; m_init = 0;
    end else begin
      cmd = reg_wr && reg_addr == 2'd0;
      clr = reg_wr && reg_addr == 2'd1 && reg_wdata[0];
      if (cmd && !(m_state == 0 && init_done)) m_err = 1;
      if (m_state == 0) begin
        if (cmd && init_done) begin
          m_state = 2; m_req = 1; m_we = reg_wdata[31];
          m_addr = int'(reg_wdata[30:16]); m_wd = int'(reg_wdata[15:0]);
        end
      end else if (m_state == 2) begin
        if (dev_ack) begin m_req = 0; m_state = m_we ? 0 : 4; end
      end else if (m_state == 4) begin
        if (dev_ack) begin m_rd = int'(dev_rdata); m_state = 6; end
      end else if (m_state == 6) begin
        if (clr) m_state = 0;
      end
      m_init = init_done;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2/R4/R5 state", int'(status[18:16]), m_state);
      chk("R4 read data", int'(status[15:0]), m_rd);
      chk("R8 init flag", int'(status[19]), int'(m_init));
      chk("R7 error flag", int'(status[20]), int'(m_err));
      chk("R8 upper zero", int'(status[31:21]), 0);
      chk("R3 dev_req", int'(dev_req), int'(m_req));
      chk("R2 dev_we", int'(dev_we), int'(m_we));
      chk("R2 dev_addr", int'(dev_addr), m_addr);
      chk("R2 dev_wdata", int'(dev_wdata), m_wd);
    end
  end

  task automatic regw(logic [1:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic ack(logic [15:0] d);
    dev_ack = 1; dev_rdata = d;
    @(negedge clk);
    dev_ack = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 reset state", int'(status), 0);
    rst = 0;
    // R7 command before init_done is ignored
    regw(2'd0, 32'h8001_1234);
    idle(2);
    chk("R7 reject before init", int'(status[20]), 1);
    init_done = 1;
    idle(1);
    // R2 R3 write transfer, ack after hold
    regw(2'd0, 32'h8123_ABCD);
    idle(3);
    chk("R3 req held", int'(dev_req), 1);
    ack(16'h0);
    chk("R3 write back to idle", int'(status[18:16]), 0);
    // R6 valid-clear in IDLE, R9 ack in IDLE
    regw(2'd1, 32'h1);
    ack(16'hFFFF);
    chk("R9 idle ack ignored", int'(status[15:0]), 0);
    // R4 R5 read
    regw(2'd0, 32'h0055_0000);
    regw(2'd1, 32'h1);               // R6 valid-clear in REQ
    regw(2'd0, 32'h8000_0001);       // R7 busy reject
    ack(16'h0);
    chk("R4 wfdle", int'(status[18:16]), 4);
    idle(2);
    ack(16'hBEEF);
    chk("R4 captured", int'(status[15:0]), 16'hBEEF);
    ack(16'h1111);                   // R9 ack in WFVLDCLR
    regw(2'd1, 32'h2);               // R6 bit0 clear
    regw(2'd2, 32'h1);               // R6 other offset
    chk("R5 still waiting", int'(status[18:16]), 6);
    regw(2'd1, 32'h1);
    chk("R5 cleared to idle", int'(status[18:16]), 0);
    chk("R5 data retained", int'(status[15:0]), 16'hBEEF);
    // random collisions
    for (int i = 0; i < 3000; i++) begin
      reg_wr    = ($urandom_range(0, 9) < 4);
      reg_addr  = 2'($urandom_range(0, 3));
      reg_wdata = $urandom;
      dev_ack   = ($urandom_range(0, 9) < 4);
      dev_rdata = 16'($urandom);
      init_done = ($urandom_range(0, 19) != 0);
      if (i == 1500) rst = 1;
      if (i == 1502) rst = 0;
      @(negedge clk);
    end
    reg_wr = 0; dev_ack = 0;
    idle(2);
    finish_run();
  end
endmodule